// File: doc/BRIEF.md
# Video Acquisition Window Controller

This block marks which part of an incoming video stream a downstream scaler should take, and reports which field of the frame is being received. It counts qualified source pixels along each line and counts the lines that carry pixels. Both counts restart on selectable edges of the horizontal and vertical reference inputs. The window opens once both source counts reach a programmed offset. It closes once the scaler has reported a programmed number of target pixels on the line and a programmed number of target lines in the field.

On the selected vertical reference edge the block also captures the level of the horizontal reference as a field identifier, which can be inverted. It emits a one-cycle field-start pulse that downstream logic can use to select per-field tasks. A separate strobe flags each qualified pixel that falls inside the programmed source rectangle (offset plus length in each dimension). The six geometry values are parallel inputs. They are captured at each selected vertical edge, so a change during a field does not disturb that field.

Top module: `acq_window_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `win_active`, `src_take`, `field_id` and `field_start` to 0 and zeroes the captured geometry, so the window stays closed until the first selected vertical edge.
- R2: `vref_rise`=0 selects the falling edge of `vref` and 1 selects the rising edge. The edge is seen in the cycle where `vref` differs from its previous sample. `field_start` is 1 in the cycle after that clock edge and 0 otherwise. All counts restart at that edge.
- R3: At the selected vertical edge, `field_id` takes the value `href XOR fid_inv` sampled at that same clock edge, and holds it until the next selected vertical edge. 0 denotes the first field.
- R4: The pixel count advances only on cycles with `pix_vld`=1. It restarts at each horizontal edge, which is rising for `href_rise`=1 and falling for 0.
- R5: At a horizontal edge, the line count advances only if the ending line held at least one qualified pixel.
- R6: `win_active` is 1 when the pixel count is at least `cfg_h_off`, the line count is at least `cfg_v_off`, the target pixel count is below `cfg_h_tgt` and the target line count is below `cfg_v_tgt`. It reflects the counts after each clock edge.
- R7: `tgt_pix` strobes advance a target pixel count. This count restarts at each horizontal and vertical edge and closes the window for the rest of the line once it reaches `cfg_h_tgt`.
- R8: `tgt_line` strobes advance a target line count that restarts only at the vertical edge. A vertical edge that arrives before `cfg_v_tgt` is reached cuts the window short.
- R9: A target size of 0 in either dimension keeps `win_active` at 0.
- R10: All counts saturate at 4095 and never wrap.
- R11: The six geometry inputs take effect only at the next selected vertical edge.
- R12: `src_take` is 1 in the cycle after a qualified pixel whose pixel index lies in [`cfg_h_off`, `cfg_h_off`+`cfg_h_len`) and whose line index lies in [`cfg_v_off`, `cfg_v_off`+`cfg_v_len`). Indices count from 0 and the sums are taken without overflow.
- R13: A reference edge takes priority over a qualified pixel or `tgt_pix` strobe in the same cycle. That pixel or strobe is neither counted nor taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld | input | 1 | Qualified source pixel strobe |
| href | input | 1 | Horizontal reference |
| vref | input | 1 | Vertical reference |
| tgt_pix | input | 1 | Scaler emitted a target pixel |
| tgt_line | input | 1 | Scaler emitted a target line |
| href_rise | input | 1 | 1: line boundary on rising `href`, 0: falling |
| vref_rise | input | 1 | 1: field boundary on rising `vref`, 0: falling |
| fid_inv | input | 1 | Invert the detected field identifier |
| cfg_h_off | input | 12 | Source pixel offset |
| cfg_h_len | input | 12 | Source pixel length |
| cfg_h_tgt | input | 12 | Target pixels per line |
| cfg_v_off | input | 12 | Source line offset |
| cfg_v_len | input | 12 | Source line length |
| cfg_v_tgt | input | 12 | Target lines per field |
| win_active | output | 1 | Acquisition window open |
| src_take | output | 1 | Last qualified pixel was inside the source rectangle |
| field_id | output | 1 | Field identifier |
| field_start | output | 1 | One-cycle pulse after the selected vertical edge |

## Verification
The assertions assume that selected vertical edges are never on adjacent cycles, and that reset is held for at least two cycles. Under those assumptions `field_start` cannot repeat and `$past` never reaches before reset. The stimulus toggles `vref` only inside a field-start pair that spans two cycles and holds reset for four cycles. It changes the edge-select bits only between fields, while `vref` is steady. Coincident edges and pixels are applied only in a dedicated directed case, where priority is defined.

// File: rtl/acqw_pkg.sv
package acqw_pkg;
  parameter int unsigned ACQ_CW = 12;

  typedef logic [ACQ_CW-1:0] acq_cnt_t;

  // captured window geometry, loaded at each selected vertical edge
  typedef struct packed {
    acq_cnt_t h_off;
    acq_cnt_t h_len;
    acq_cnt_t h_tgt;
    acq_cnt_t v_off;
    acq_cnt_t v_len;
    acq_cnt_t v_tgt;
  } acq_geom_t;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } ref_edge_e;
endpackage

// File: rtl/acqw_edge_det.sv
module acqw_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] sig,
  input  logic [N-1:0] rise_sel,
  output logic [N-1:0] pulse
);
  import acqw_pkg::*;

  logic [N-1:0] sig_q;

  // delay register follows the input also during reset, so no false edge at release
  always_ff @(posedge clk) sig_q <= sig;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign pulse[i] = (ref_edge_e'(rise_sel[i]) == EDGE_RISE) ? (sig[i] & ~sig_q[i])
                                                              : (~sig[i] & sig_q[i]);
  end
endmodule

// File: rtl/acqw_sat_cnt.sv
module acqw_sat_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_d,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] CMAX = '1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (inc && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/acqw_field.sv
module acqw_field
  import acqw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      v_edge,
  input  logic      href,
  input  logic      fid_inv,
  input  acq_geom_t cfg,
  output acq_geom_t geom_d,
  output acq_geom_t geom_q,
  output logic      field_id,
  output logic      field_start
);
  assign geom_d = v_edge ? cfg : geom_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      geom_q      <= '0;
      field_id    <= 1'b0;
      field_start <= 1'b0;
    end else begin
      geom_q      <= geom_d;
      field_start <= v_edge;
      if (v_edge) field_id <= href ^ fid_inv;
    end
  end
endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl
  import acqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_vld,
  input  logic              href,
  input  logic              vref,
  input  logic              tgt_pix,
  input  logic              tgt_line,
  input  logic              href_rise,
  input  logic              vref_rise,
  input  logic              fid_inv,
  input  logic [ACQ_CW-1:0] cfg_h_off,
  input  logic [ACQ_CW-1:0] cfg_h_len,
  input  logic [ACQ_CW-1:0] cfg_h_tgt,
  input  logic [ACQ_CW-1:0] cfg_v_off,
  input  logic [ACQ_CW-1:0] cfg_v_len,
  input  logic [ACQ_CW-1:0] cfg_v_tgt,
  output logic              win_active,
  output logic              src_take,
  output logic              field_id,
  output logic              field_start
);
  localparam int unsigned CW = ACQ_CW;
  localparam int unsigned NREF = 2;
  localparam int unsigned H_IX = 0;
  localparam int unsigned V_IX = 1;

  logic [NREF-1:0] ref_pulse;
  logic            h_edge, v_edge, line_brk;

  acqw_edge_det #(.N(NREF)) u_edge (
    .clk      (clk),
    .sig      ({vref, href}),
    .rise_sel ({vref_rise, href_rise}),
    .pulse    (ref_pulse)
  );

  assign h_edge   = ref_pulse[H_IX];
  assign v_edge   = ref_pulse[V_IX];
  assign line_brk = h_edge | v_edge;

  acq_geom_t cfg_in, geom_d, geom_q;
  assign cfg_in = '{h_off: cfg_h_off, h_len: cfg_h_len, h_tgt: cfg_h_tgt,
                    v_off: cfg_v_off, v_len: cfg_v_len, v_tgt: cfg_v_tgt};

  acqw_field u_field (
    .clk         (clk),
    .rst         (rst),
    .v_edge      (v_edge),
    .href        (href),
    .fid_inv     (fid_inv),
    .cfg         (cfg_in),
    .geom_d      (geom_d),
    .geom_q      (geom_q),
    .field_id    (field_id),
    .field_start (field_start)
  );

  // line holds a qualified pixel
  logic line_has_pix;
  always_ff @(posedge clk) begin
    if (rst || line_brk) line_has_pix <= 1'b0;
    else if (pix_vld)    line_has_pix <= 1'b1;
  end

  logic [CW-1:0] pc_d, pc_q, lc_d, lc_q, tpc_d, tpc_q, tlc_d, tlc_q;

  acqw_sat_cnt #(.W(CW)) u_pix_cnt (
    .clk(clk), .rst(rst), .clr(line_brk), .inc(pix_vld),
    .cnt_d(pc_d), .cnt_q(pc_q)
  );
  acqw_sat_cnt #(.W(CW)) u_line_cnt (
    .clk(clk), .rst(rst), .clr(v_edge), .inc(h_edge & line_has_pix),
    .cnt_d(lc_d), .cnt_q(lc_q)
  );
  acqw_sat_cnt #(.W(CW)) u_tpix_cnt (
    .clk(clk), .rst(rst), .clr(line_brk), .inc(tgt_pix),
    .cnt_d(tpc_d), .cnt_q(tpc_q)
  );
  acqw_sat_cnt #(.W(CW)) u_tline_cnt (
    .clk(clk), .rst(rst), .clr(v_edge), .inc(tgt_line),
    .cnt_d(tlc_d), .cnt_q(tlc_q)
  );

  // window from next-state counts, so the flag is aligned with the counters
  logic h_open, h_shut, v_open, v_shut, win_d;
  assign h_open = pc_d  >= geom_d.h_off;
  assign h_shut = tpc_d >= geom_d.h_tgt;
  assign v_open = lc_d  >= geom_d.v_off;
  assign v_shut = tlc_d >= geom_d.v_tgt;
  assign win_d  = h_open & ~h_shut & v_open & ~v_shut;

  // source rectangle test on the index of the pixel arriving now
  logic [CW:0] h_end, v_end;
  logic        in_h, in_v, take_d;
  assign h_end  = {1'b0, geom_d.h_off} + {1'b0, geom_d.h_len};
  assign v_end  = {1'b0, geom_d.v_off} + {1'b0, geom_d.v_len};
  assign in_h   = (pc_q >= geom_d.h_off) && ({1'b0, pc_q} < h_end);
  assign in_v   = (lc_q >= geom_d.v_off) && ({1'b0, lc_q} < v_end);
  assign take_d = pix_vld & ~line_brk & in_h & in_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_active <= 1'b0;
      src_take   <= 1'b0;
    end else begin
      win_active <= win_d;
      src_take   <= take_d;
    end
  end
endmodule

// File: rtl/acqw_chk.sv
module acqw_chk
  import acqw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pix_vld,
  input logic              href,
  input logic              fid_inv,
  input logic              win_active,
  input logic              src_take,
  input logic              field_id,
  input logic              field_start,
  input acq_geom_t         geom,
  input logic [ACQ_CW-1:0] tpc,
  input logic [ACQ_CW-1:0] tlc
);
  localparam logic [ACQ_CW-1:0] CMAX = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!win_active && !src_take && !field_id && !field_start));

  // R2
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !field_start);

  // R3
  fid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!field_start && !$past(rst)) |-> $stable(field_id));

  // R3
  fid_value_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |-> (field_id == ($past(href) ^ $past(fid_inv))));

  // R7
  hclose_chk: assert property (@(posedge clk) disable iff (rst)
    win_active |-> (tpc < geom.h_tgt));

  // R9
  zero_size_chk: assert property (@(posedge clk) disable iff (rst)
    (geom.h_tgt == '0 || geom.v_tgt == '0) |-> !win_active);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tlc) == CMAX && !field_start) |-> (tlc == CMAX));

  // R12
  take_qual_chk: assert property (@(posedge clk) disable iff (rst)
    src_take |-> $past(pix_vld));
endmodule

bind acq_window_ctrl acqw_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_vld     (pix_vld),
  .href        (href),
  .fid_inv     (fid_inv),
  .win_active  (win_active),
  .src_take    (src_take),
  .field_id    (field_id),
  .field_start (field_start),
  .geom        (geom_q),
  .tpc         (tpc_q),
  .tlc         (tlc_q)
);

// File: tb/acq_window_ctrl_bench.sv
`timescale 1ns/1ps
module acq_window_ctrl_bench;
  import acqw_pkg::*;
  localparam int MAXC = (1 << ACQ_CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic pix_vld = 0, href = 0, vref = 0, tgt_pix = 0, tgt_line = 0;
  logic href_rise = 0, vref_rise = 0, fid_inv = 0;
  logic [ACQ_CW-1:0] cfg_h_off = '0, cfg_h_len = '0, cfg_h_tgt = '0;
  logic [ACQ_CW-1:0] cfg_v_off = '0, cfg_v_len = '0, cfg_v_tgt = '0;
  logic win_active, src_take, field_id, field_start;

  acq_window_ctrl u_acq_window_ctrl (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .href(href), .vref(vref),
    .tgt_pix(tgt_pix), .tgt_line(tgt_line), .href_rise(href_rise),
    .vref_rise(vref_rise), .fid_inv(fid_inv),
    .cfg_h_off(cfg_h_off), .cfg_h_len(cfg_h_len), .cfg_h_tgt(cfg_h_tgt),
    .cfg_v_off(cfg_v_off), .cfg_v_len(cfg_v_len), .cfg_v_tgt(cfg_v_tgt),
    .win_active(win_active), .src_take(src_take),
    .field_id(field_id), .field_start(field_start)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_hp, m_vp, m_pc, m_lc, m_lhp, m_tpc, m_tlc, m_fid, m_fs, m_take, m_win;
  int s_ho, s_hl, s_ht, s_vo, s_vl, s_vt;

  function automatic int sat(int x);
    return (x < MAXC) ? x + 1 : MAXC;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(bit pv, bit h, bit v, bit tp, bit tl);
    bit he, ve;
    pix_vld = pv; href = h; vref = v; tgt_pix = tp; tgt_line = tl;
    @(posedge clk);
    he = href_rise ? (h && m_hp == 0) : (!h && m_hp == 1);
    ve = vref_rise ? (v && m_vp == 0) : (!v && m_vp == 1);
    m_hp = h; m_vp = v;
    if (ve) begin
      s_ho = cfg_h_off; s_hl = cfg_h_len; s_ht = cfg_h_tgt;
      s_vo = cfg_v_off; s_vl = cfg_v_len; s_vt = cfg_v_tgt;
      m_pc = 0; m_lc = 0; m_lhp = 0; m_tpc = 0; m_tlc = 0;
      m_fid = int'(h ^ fid_inv); m_fs = 1; m_take = 0;
    end else begin
      m_fs = 0;
      if (he) begin
        if (m_lhp != 0) m_lc = sat(m_lc);
        m_pc = 0; m_lhp = 0; m_tpc = 0; m_take = 0;
        if (tl) m_tlc = sat(m_tlc);
      end else begin
        m_take = (pv && m_pc >= s_ho && m_pc < s_ho + s_hl &&
                  m_lc >= s_vo && m_lc < s_vo + s_vl) ? 1 : 0;
        if (pv) begin m_pc = sat(m_pc); m_lhp = 1; end
        if (tp) m_tpc = sat(m_tpc);
        if (tl) m_tlc = sat(m_tlc);
      end
    end
    m_win = (m_lc >= s_vo && m_tlc < s_vt && m_pc >= s_ho && m_tpc < s_ht) ? 1 : 0;
    #1;
    chk(cur_req, "win_active", int'(win_active), m_win);
    chk("R12", "src_take", int'(src_take), m_take);
    chk("R3", "field_id", int'(field_id), m_fid);
    chk("R2", "field_start", int'(field_start), m_fs);
  endtask

  task automatic do_reset();
    rst = 1'b1; pix_vld = 0; href = 0; vref = 0; tgt_pix = 0; tgt_line = 0;
    repeat (4) @(posedge clk);
    #1;
    m_hp = 0; m_vp = 0; m_pc = 0; m_lc = 0; m_lhp = 0; m_tpc = 0; m_tlc = 0;
    m_fid = 0; m_fs = 0; m_take = 0; m_win = 0;
    s_ho = 0; s_hl = 0; s_ht = 0; s_vo = 0; s_vl = 0; s_vt = 0;
    rst = 1'b0;
    chk("R1", "win_active", int'(win_active), 0);
    chk("R1", "src_take", int'(src_take), 0);
    chk("R1", "field_id", int'(field_id), 0);
    chk("R1", "field_start", int'(field_start), 0);
  endtask

  task automatic start_field(bit lvl);
    if (!vref_rise) begin tick(0, href, 1, 0, 0); tick(0, lvl, 0, 0, 0); end
    else            begin tick(0, href, 0, 0, 0); tick(0, lvl, 1, 0, 0); end
  endtask

  task automatic one_line(int np, bit gaps, bit tl_en);
    if (href_rise) begin tick(0, 0, vref, 0, 0); tick(0, 1, vref, 0, 0); end
    else           begin tick(0, 1, vref, 0, 0); tick(0, 0, vref, 0, 0); end
    for (int i = 0; i < np; i++) begin
      tick(1, href, vref, i >= 1, 0);
      if (gaps && i % 2 == 1) tick(0, href, vref, 0, 0);
    end
    tick(0, href, vref, 0, tl_en && np > 0);
  endtask

  task automatic set_cfg(int ho, int hl, int ht, int vo, int vl, int vt);
    cfg_h_off = ho[ACQ_CW-1:0]; cfg_h_len = hl[ACQ_CW-1:0]; cfg_h_tgt = ht[ACQ_CW-1:0];
    cfg_v_off = vo[ACQ_CW-1:0]; cfg_v_len = vl[ACQ_CW-1:0]; cfg_v_tgt = vt[ACQ_CW-1:0];
  endtask

  bit done = 0;

  initial begin
    do_reset();
    // R1: window stays closed before any field edge even with nonzero inputs
    set_cfg(0, 4, 4, 0, 4, 4);
    cur_req = "R1";
    one_line(3, 0, 1);

    // near-exhaustive sweep of offsets, target sizes and edge modes
    for (int ix = 0; ix < 144; ix++) begin
      int ho, ht, vo, vt;
      ho = ix % 4; ht = (ix / 4) % 4; vo = (ix / 16) % 3; vt = (ix / 48) % 3;
      href_rise = ix[0]; vref_rise = ix[1]; fid_inv = ix[2];
      set_cfg(ho, (ho + ht) % 4, ht, vo, vt, vt);
      cur_req = (ht == 0 || vt == 0) ? "R9" : "R6";
      start_field(ix[3]);
      for (int l = 0; l < 4; l++) one_line(5, l[0], 1);
    end

    // R4: gaps in qualified pixels do not advance the offset
    href_rise = 1; vref_rise = 0; fid_inv = 0; cur_req = "R4";
    set_cfg(3, 2, 9, 0, 9, 9);
    start_field(0);
    one_line(6, 1, 0);

    // R5: empty lines are not counted toward the vertical offset
    cur_req = "R5";
    set_cfg(0, 9, 9, 2, 9, 9);
    start_field(1);
    one_line(0, 0, 0); one_line(2, 0, 0); one_line(0, 0, 0);
    one_line(0, 0, 0); one_line(2, 0, 0); one_line(3, 0, 0);

    // R7: target pixels close the window within a line, reopen on the next
    cur_req = "R7";
    set_cfg(0, 9, 2, 0, 9, 9);
    start_field(0);
    one_line(6, 0, 0); one_line(6, 1, 0);

    // R8: field ends before the target line count, window cut
    cur_req = "R8";
    set_cfg(0, 9, 9, 1, 9, 9);
    start_field(0);
    one_line(3, 0, 1); one_line(3, 0, 1);
    start_field(1);
    chk("R8", "win_after_cut", int'(win_active), 0);

    // R11: geometry change mid-field waits for the next field edge
    cur_req = "R11";
    set_cfg(0, 9, 5, 0, 9, 5);
    start_field(0);
    set_cfg(0, 9, 0, 0, 9, 0);
    one_line(3, 0, 0);
    chk("R11", "win_old_cfg", int'(win_active), 1);
    start_field(0);
    chk("R11", "win_new_cfg", int'(win_active), 0);

    // R13: pixel and target strobe coinciding with a line edge are dropped
    cur_req = "R13";
    set_cfg(1, 3, 2, 0, 9, 9);
    start_field(0);
    tick(0, 0, vref, 0, 0);
    tick(1, 1, vref, 1, 0);
    tick(0, 1, vref, 0, 0);
    chk("R13", "win_edge_pix", int'(win_active), 0);
    tick(1, 1, vref, 1, 0);
    tick(1, 1, vref, 1, 0);

    // R10: pixel count saturates and the window stays open past 4095
    cur_req = "R10";
    set_cfg(MAXC, 1, 5, 0, 5, 5);
    start_field(0);
    tick(0, 0, vref, 0, 0);
    tick(0, 1, vref, 0, 0);
    for (int i = 0; i < MAXC + 6; i++) tick(1, 1, vref, 0, 0);
    chk("R10", "win_saturated", int'(win_active), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule